// File: doc/BRIEF.md
# Privileged Register Access Router

This block decides what happens when a core reads or writes its interrupt priority mask register through the system-register path. Each request carries the current exception level and a set of configuration flags. These flags say whether levels 2 and 3 are present or enabled, and whether each of those levels runs in the 32-bit execution state. They also cover the hypervisor trap controls, the virtual-interrupt routing controls, the secure-monitor routing controls, the monitor-mode status and the per-level register-interface enables. The router turns all of this into exactly one outcome. The possible outcomes are: undefined instruction, trap to level 2 (64-bit or 32-bit style), trap to level 3 (64-bit or 32-bit monitor style), redirect to the virtual mask register, or access the physical mask register.

The rules are checked as an ordered list in which the first match wins. The list depends on the requesting level and on the execution state of the level that would take the trap. Reads and writes go through the same list, and the access direction is carried alongside the result. The decision is registered, so the result appears one clock after the request. A trap class value goes with every level-2 trap. Carrying out the trap itself is left to the surrounding core logic.

Top module: `pmr_access_router`

## Requirements
- R1: A request with `cur_el` = 0 always produces the undefined outcome, whatever the flags are.
- R2: At level 1, if `el2_en` and `hyp_grp_trap` are both set, the result is a level-2 trap. The trap is 32-bit style when `el2_is32` = 1 and 64-bit style otherwise. This check has the highest priority at level 1.
- R3: At level 1, when R2 does not apply, `el2_en` together with `hyp_ic_trap` gives a level-2 trap, with the same style split as in R2.
- R4: At level 1, when R2 and R3 do not apply, `el2_en` together with either `virt_fiq_route` or `virt_irq_route` gives the virtual-redirect outcome.
- R5: At level 1, when R2 to R4 do not apply, the result is a level-3 trap if `el3_present`, `mon_irq_route` and `mon_fiq_route` are all set. The trap is monitor style when `el3_is32` = 1 and 64-bit style otherwise. The trap is skipped, and the physical outcome results, when `el3_is32` = 1 and `in_monitor` = 1.
- R6: A request at level 2 with `el2_if_en` = 0, or at level 3 with `el3_if_en` = 0, produces the undefined outcome. This check comes before any other check at those levels.
- R7: At level 2 with the interface enabled, `el3_present` together with both monitor routing bits gives a level-3 trap. The style follows `el3_is32`, and `in_monitor` has no effect on it.
- R8: When no earlier rule matches, the result is physical access. `req_write` does not change the outcome and is returned on `out_write`.
- R9: `outcome` bit positions are: 0 undefined, 1 level-2 trap 64-bit, 2 level-2 trap 32-bit, 3 level-3 trap 64-bit, 4 level-3 trap monitor style, 5 virtual redirect, 6 physical. A request sampled at a rising edge with `req_valid` = 1 shows `out_valid` = 1 after that edge with exactly one `outcome` bit set. With no request, `out_valid` and `outcome` are all zero.
- R10: `syndrome` is 3 on either level-2 trap outcome and 0 in every other case.
- R11: While `rst` is high, `out_valid`, `out_write`, `outcome` and `syndrome` are all cleared after each clock edge, even if a request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| el2_en | input | 1 | Level 2 enabled |
| el3_present | input | 1 | Level 3 implemented |
| el2_is32 | input | 1 | Level 2 runs 32-bit |
| el3_is32 | input | 1 | Level 3 runs 32-bit |
| hyp_grp_trap | input | 1 | Hypervisor register-group trap control |
| hyp_ic_trap | input | 1 | Hypervisor interrupt-controller common trap control |
| virt_fiq_route | input | 1 | FIQ virtual routing control |
| virt_irq_route | input | 1 | IRQ virtual routing control |
| mon_irq_route | input | 1 | Monitor IRQ routing control |
| mon_fiq_route | input | 1 | Monitor FIQ routing control |
| in_monitor | input | 1 | Core is in monitor mode |
| el2_if_en | input | 1 | Level-2 register interface enable |
| el3_if_en | input | 1 | Level-3 register interface enable |
| out_valid | output | 1 | Result valid |
| out_write | output | 1 | Direction of the decided request |
| outcome | output | 7 | One-hot outcome, positions as in R9 |
| syndrome | output | 3 | Trap class, 3 on level-2 traps |

## Verification
Every decision goes through one register, so a wrong priority in a chain shows up at the ports one clock after the request. It appears as a different `outcome` bit, and often as a `syndrome` mismatch as well. The bench walks every combination of level and flag, so each ordering between neighbouring rules is tested in both directions. A stuck or leaking output register shows up on the idle cycles the bench inserts, where `outcome` must read zero.

// File: rtl/pmr_route_pkg.sv
package pmr_route_pkg;
  localparam int OUTC_N   = 7;
  localparam int OC_UNDEF = 0;
  localparam int OC_T2_64 = 1;
  localparam int OC_T2_32 = 2;
  localparam int OC_T3_64 = 3;
  localparam int OC_T3_MN = 4;
  localparam int OC_VIRT  = 5;
  localparam int OC_PHYS  = 6;

  typedef logic [OUTC_N-1:0] outc_t;

  function automatic outc_t oc_bit(input int idx);
    outc_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pmr_el1_chain.sv
module pmr_el1_chain
  import pmr_route_pkg::*;
(
  input  logic  el2_en,
  input  logic  el2_is32,
  input  logic  el3_present,
  input  logic  el3_is32,
  input  logic  grp_trap,
  input  logic  ic_trap,
  input  logic  virt_fiq,
  input  logic  virt_irq,
  input  logic  mon_irq,
  input  logic  mon_fiq,
  input  logic  in_monitor,
  output outc_t res
);
  outc_t t2;
  outc_t t3;
  logic  mon_exempt;

  assign t2 = el2_is32 ? oc_bit(OC_T2_32) : oc_bit(OC_T2_64);
  assign t3 = el3_is32 ? oc_bit(OC_T3_MN) : oc_bit(OC_T3_64);
  assign mon_exempt = el3_is32 & in_monitor;

  always_comb begin
    if (el2_en && grp_trap)                                  res = t2;
    else if (el2_en && ic_trap)                              res = t2;
    else if (el2_en && (virt_fiq || virt_irq))               res = oc_bit(OC_VIRT);
    else if (el3_present && mon_irq && mon_fiq && !mon_exempt) res = t3;
    else                                                     res = oc_bit(OC_PHYS);
  end
endmodule

// File: rtl/pmr_upper_chain.sv
module pmr_upper_chain
  import pmr_route_pkg::*;
#(
  parameter int LEVEL = 2
)(
  input  logic  if_en,
  input  logic  el3_present,
  input  logic  el3_is32,
  input  logic  mon_irq,
  input  logic  mon_fiq,
  output outc_t res
);
  generate
    if (LEVEL == 2) begin : g_lvl2
      always_comb begin
        if (!if_en)
          res = oc_bit(OC_UNDEF);
        else if (el3_present && mon_irq && mon_fiq)
          res = el3_is32 ? oc_bit(OC_T3_MN) : oc_bit(OC_T3_64);
        else
          res = oc_bit(OC_PHYS);
      end
    end else begin : g_lvl3
      logic unused_route;
      assign unused_route = ^{el3_present, el3_is32, mon_irq, mon_fiq};
      assign res = if_en ? oc_bit(OC_PHYS) : oc_bit(OC_UNDEF);
    end
  endgenerate
endmodule

// File: rtl/pmr_route_reg.sv
module pmr_route_reg #(
  parameter int W  = 7,
  parameter int SW = 3
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_write,
  input  logic [W-1:0]  in_outc,
  input  logic [SW-1:0] in_synd,
  output logic          out_valid,
  output logic          out_write,
  output logic [W-1:0]  out_outc,
  output logic [SW-1:0] out_synd
);
  always_ff @(posedge clk) begin
    if (rst || !in_valid) begin
      out_valid <= 1'b0;
      out_write <= 1'b0;
      out_outc  <= '0;
      out_synd  <= '0;
    end else begin
      out_valid <= 1'b1;
      out_write <= in_write;
      out_outc  <= in_outc;
      out_synd  <= in_synd;
    end
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_outc) == 1);
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_outc == '0 && out_synd == '0));
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
endmodule

// File: rtl/pmr_access_router.sv
module pmr_access_router
  import pmr_route_pkg::*;
#(
  parameter int SYND_W  = 3,
  parameter int TRAP_EC = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        cur_el,
  input  logic              el2_en,
  input  logic              el3_present,
  input  logic              el2_is32,
  input  logic              el3_is32,
  input  logic              hyp_grp_trap,
  input  logic              hyp_ic_trap,
  input  logic              virt_fiq_route,
  input  logic              virt_irq_route,
  input  logic              mon_irq_route,
  input  logic              mon_fiq_route,
  input  logic              in_monitor,
  input  logic              el2_if_en,
  input  logic              el3_if_en,
  output logic              out_valid,
  output logic              out_write,
  output logic [OUTC_N-1:0] outcome,
  output logic [SYND_W-1:0] syndrome
);
  outc_t              r_el1, r_el2, r_el3, sel;
  logic [SYND_W-1:0]  synd_d;

  pmr_el1_chain u_el1 (
    .el2_en(el2_en), .el2_is32(el2_is32), .el3_present(el3_present),
    .el3_is32(el3_is32), .grp_trap(hyp_grp_trap), .ic_trap(hyp_ic_trap),
    .virt_fiq(virt_fiq_route), .virt_irq(virt_irq_route),
    .mon_irq(mon_irq_route), .mon_fiq(mon_fiq_route),
    .in_monitor(in_monitor), .res(r_el1)
  );

  pmr_upper_chain #(.LEVEL(2)) u_el2 (
    .if_en(el2_if_en), .el3_present(el3_present), .el3_is32(el3_is32),
    .mon_irq(mon_irq_route), .mon_fiq(mon_fiq_route), .res(r_el2)
  );

  pmr_upper_chain #(.LEVEL(3)) u_el3 (
    .if_en(el3_if_en), .el3_present(el3_present), .el3_is32(el3_is32),
    .mon_irq(mon_irq_route), .mon_fiq(mon_fiq_route), .res(r_el3)
  );

  always_comb begin
    case (cur_el)
      2'd1:    sel = r_el1;
      2'd2:    sel = r_el2;
      2'd3:    sel = r_el3;
      default: sel = oc_bit(OC_UNDEF);
    endcase
  end

  assign synd_d = (sel[OC_T2_64] | sel[OC_T2_32]) ? SYND_W'(TRAP_EC) : '0;

  pmr_route_reg #(.W(OUTC_N), .SW(SYND_W)) u_reg (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_write(req_write),
    .in_outc(sel), .in_synd(synd_d),
    .out_valid(out_valid), .out_write(out_write),
    .out_outc(outcome), .out_synd(syndrome)
  );

  assert_el0_undef_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_el == 2'd0) |=> outcome[OC_UNDEF]);
  assert_grp_first_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_el == 2'd1 && el2_en && hyp_grp_trap && !el2_is32) |=> outcome[OC_T2_64]);
  assert_mon_exempt_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_el == 2'd1 && !el2_en && el3_present && el3_is32 && in_monitor
     && mon_irq_route && mon_fiq_route) |=> outcome[OC_PHYS]);
  assert_if_off_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_el == 2'd3 && !el3_if_en) |=> outcome[OC_UNDEF]);
  assert_no_exempt_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && cur_el == 2'd2 && el2_if_en && el3_present && el3_is32
     && mon_irq_route && mon_fiq_route) |=> outcome[OC_T3_MN]);
  assert_syndrome_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (syndrome == ((outcome[OC_T2_64] || outcome[OC_T2_32]) ? SYND_W'(TRAP_EC) : '0)));
  assert_write_echo_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_write == $past(req_write));
endmodule

// File: tb/tb_pmr_access_router.sv
module tb_pmr_access_router;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, req_valid, req_write;
  logic [1:0] cur_el;
  logic el2_en, el3_present, el2_is32, el3_is32, hyp_grp_trap, hyp_ic_trap;
  logic virt_fiq_route, virt_irq_route, mon_irq_route, mon_fiq_route;
  logic in_monitor, el2_if_en, el3_if_en;
  logic out_valid, out_write;
  logic [6:0] outcome;
  logic [2:0] syndrome;

  pmr_access_router dut (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct packed {
    logic       v;
    logic       w;
    logic [6:0] oc;
    logic [2:0] sy;
  } exp_t;
  exp_t  q[$];
  string tq[$];

  // Expected outcome from the requirement text; position numbers as listed in R9.
  task automatic expect_of(input logic [1:0] el, input logic [12:0] f,
                           output int pos, output string tag);
    logic e2, e3, e2w, e3w, grp, ic, vf, vi, mi, mf, mon, if2, if3;
    {if3, if2, mon, mf, mi, vi, vf, ic, grp, e3w, e2w, e3, e2} = f;
    pos = 6; tag = "R8";
    if (el == 2'd0) begin pos = 0; tag = "R1"; end
    else if (el == 2'd3) begin
      if (!if3) begin pos = 0; tag = "R6"; end
    end else if (el == 2'd2) begin
      if (!if2) begin pos = 0; tag = "R6"; end
      else if (e3 && mi && mf) begin pos = e3w ? 4 : 3; tag = "R7"; end
    end else begin
      if (e2 && grp) begin pos = e2w ? 2 : 1; tag = "R2"; end
      else if (e2 && ic) begin pos = e2w ? 2 : 1; tag = "R3"; end
      else if (e2 && (vf || vi)) begin pos = 5; tag = "R4"; end
      else if (e3 && mi && mf) begin
        tag = "R5";
        if (e3w && mon) pos = 6;
        else pos = e3w ? 4 : 3;
      end
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [1:0] el,
                       input logic [12:0] f);
    exp_t  e;
    int    pos;
    string tag;
    @(negedge clk);
    req_valid = v; req_write = w; cur_el = el;
    {el3_if_en, el2_if_en, in_monitor, mon_fiq_route, mon_irq_route, virt_irq_route,
     virt_fiq_route, hyp_ic_trap, hyp_grp_trap, el3_is32, el2_is32, el3_present, el2_en} = f;
    expect_of(el, f, pos, tag);
    e.v = v;
    e.w = v ? w : 1'b0;
    e.oc = v ? (7'd1 << pos) : 7'd0;
    e.sy = (v && (pos == 1 || pos == 2)) ? 3'd3 : 3'd0;
    q.push_back(e);
    tq.push_back(v ? {tag, "/R9/R10"} : "R9 idle");
  endtask

  // Monitor: compares one item per cycle, 2 ns after the capturing edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t  e;
        string t;
        e = q.pop_front();
        t = tq.pop_front();
        checks++;
        if ({out_valid, out_write, outcome, syndrome} !== {e.v, e.w, e.oc, e.sy}) begin
          fails++;
          $display("FAIL %s: got v=%b w=%b oc=%b sy=%0d, expected v=%b w=%b oc=%b sy=%0d",
                   t, out_valid, out_write, outcome, syndrome, e.v, e.w, e.oc, e.sy);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected sweep to finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b1; req_write = 1'b1; cur_el = 2'd1;
    {el3_if_en, el2_if_en, in_monitor, mon_fiq_route, mon_irq_route, virt_irq_route,
     virt_fiq_route, hyp_ic_trap, hyp_grp_trap, el3_is32, el2_is32, el3_present, el2_en} = '1;
    repeat (3) @(negedge clk);
    // R11: reset clears outputs even with a request presented
    checks++;
    if ({out_valid, out_write, outcome, syndrome} !== 12'd0) begin
      fails++;
      $display("FAIL R11: got v=%b w=%b oc=%b sy=%0d, expected all zero",
               out_valid, out_write, outcome, syndrome);
    end
    rst = 1'b0; req_valid = 1'b0;
    // exhaustive sweep over level and every flag, idle gap every 1024 requests
    for (int i = 0; i < 32768; i++) begin
      logic [14:0] b;
      b = 15'(i);
      drive(1'b1, b[0] ^ b[7], b[1:0], b[14:2]);
      if ((i % 1024) == 1023) drive(1'b0, 1'b1, 2'd1, 13'h1fff);
    end
    // directed: same input as read and as write must decide alike (R8)
    drive(1'b1, 1'b0, 2'd1, 13'b0000000000000);
    drive(1'b1, 1'b1, 2'd1, 13'b0000000000000);
    drive(1'b0, 1'b0, 2'd0, 13'd0);
    drive(1'b0, 1'b0, 2'd0, 13'd0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule